// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block turns one request of the form opcode, optional column and optional page address into the command-latch and address-latch cycles that a 512-byte-page NAND device expects on an 8-bit command/address path. Each latch cycle appears for one clock on a cycle port that marks whether the byte is a command or an address. For a page-program setup request the sequencer first emits a region-pointer command chosen from the column (first half, second half or spare area) and rebases the column to that region.

Once the cycles have been sent, the sequencer picks one of four endings. It can finish at once. It can wait a fixed chip delay. It can wait a short write-to-busy interval and then hand off to an external ready-wait engine. For a reset on a board without a busy pin, it waits the chip delay, sends a status command and then hands the status-polling wait to the engine. Three static configuration inputs set the bus width, the three-row-cycle mode and whether a busy pin exists.

The states are: S_IDLE (accepts a request), S_PTR (pointer command), S_CMD (opcode), S_COL (column byte), S_ROW_LO, S_ROW_MID and S_ROW_HI (page bytes), S_DELAY (counted delay), S_RST_STAT (status command after reset), S_WSTART (wait-engine start pulse), S_WAIT (engine running) and S_DONE (completion pulse). The transitions are:
- S_IDLE to S_PTR for program setup, otherwise to S_CMD.
- S_PTR to S_CMD.
- S_CMD to S_COL, or to S_ROW_LO, or to the ending.
- S_COL to S_ROW_LO or to the ending.
- S_ROW_LO to S_ROW_MID.
- S_ROW_MID to S_ROW_HI or to the ending.
- The ending is S_DONE when no wait is needed, and S_DELAY otherwise.
- S_DELAY on expiry to S_DONE, S_WSTART or S_RST_STAT.
- S_RST_STAT to S_WSTART, S_WSTART to S_WAIT, S_WAIT to S_DONE on wait_done, and S_DONE to S_IDLE.

Top module: `nand_sp_seq`

## Requirements
- R1: After reset req_ready is 1 and cyc_valid, wait_start and op_done are 0. A request is taken on a clock where req_valid and req_ready are both 1. req_ready then stays 0 until the clock after the one-cycle op_done pulse.
- R2: For opcode 0x80 (program setup) a pointer command comes just before the 0x80 command. A column of 512 or more gives pointer 0x50 and the column minus 512. A column from 256 to 511 gives pointer 0x01 and the column minus 256. A column below 256, or no column at all, gives pointer 0x00 and the column unchanged.
- R3: The latch cycles come on consecutive clocks, the first one on the clock after acceptance. The order is: pointer (if any), opcode, column (if present), then page bytes (if present). cyc_is_addr is 0 for command bytes and 1 for address bytes.
- R4: A present column is one address cycle carrying bits 7:0 of the (rebased) column. When cfg_bus16 is 1, the column is shifted right by one, unless the opcode is 0x90, 0xEE or 0xEF.
- R5: A present page address is sent as bits 7:0 and then bits 15:8. When cfg_row3 is 1, a third cycle follows with bits 23:16.
- R6: Opcodes 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF raise op_done on the clock after their last latch cycle and never raise wait_start.
- R7: Opcode 0x00 with neither a column nor a page address ends the same way as R6, with no wait.
- R8: Any other opcode except 0xFF, with cfg_busy_pin at 0, leaves CHIP_DELAY_CYC idle clocks after the last latch cycle, then raises op_done, and never raises wait_start.
- R9: Any opcode that is not covered by R6 or R7 (0xFF included), with cfg_busy_pin at 1, leaves TWB_CYC idle clocks and then gives a one-clock wait_start with wait_poll at 0. op_done follows on the clock after wait_done is seen.
- R10: Opcode 0xFF with cfg_busy_pin at 0 leaves CHIP_DELAY_CYC idle clocks, then sends command 0x70, then gives a one-clock wait_start with wait_poll at 1. op_done follows on the clock after wait_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_opcode | input | 8 | Command opcode |
| req_col_valid | input | 1 | Column field is present |
| req_col | input | COL_W | Column address |
| req_page_valid | input | 1 | Page field is present |
| req_page | input | PAGE_W | Page address |
| cfg_bus16 | input | 1 | Device has a 16-bit data bus |
| cfg_row3 | input | 1 | Send three page-address cycles |
| cfg_busy_pin | input | 1 | A ready/busy pin is available |
| cyc_valid | output | 1 | A latch cycle is on the port this clock |
| cyc_is_addr | output | 1 | 1 for an address cycle, 0 for a command cycle |
| cyc_byte | output | 8 | Latched byte |
| wait_start | output | 1 | One-clock start pulse for the wait engine |
| wait_poll | output | 1 | With wait_start: 1 for status polling, 0 for the ready pin |
| wait_done | input | 1 | Wait engine has finished |
| op_done | output | 1 | One-clock pulse when the request is complete |

## Verification
A wrong state register or a wrong transition shows up on the cycle port on the very clock it happens. The port then shows a missing, extra or out-of-order command or address byte, or a wrong command/address marking. A wrong ending class or a wrong delay load shows up only after the latch cycles: op_done or wait_start arrives at the wrong clock, or wait_poll has the wrong value, which can be up to CHIP_DELAY_CYC clocks later. A sequencer stuck outside idle shows as req_ready staying low after op_done.

// File: rtl/nand_sp_pkg.sv
package nand_sp_pkg;

    localparam logic [7:0] OP_READ0    = 8'h00;
    localparam logic [7:0] OP_READ1    = 8'h01;
    localparam logic [7:0] OP_READOOB  = 8'h50;
    localparam logic [7:0] OP_SEQIN    = 8'h80;
    localparam logic [7:0] OP_PAGEPROG = 8'h10;
    localparam logic [7:0] OP_ERASE1   = 8'h60;
    localparam logic [7:0] OP_ERASE2   = 8'hD0;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_READID   = 8'h90;
    localparam logic [7:0] OP_GETFEAT  = 8'hEE;
    localparam logic [7:0] OP_SETFEAT  = 8'hEF;
    localparam logic [7:0] OP_RESET    = 8'hFF;

    // How a request ends once its latch cycles are out
    typedef enum logic [1:0] {
        POST_NONE,
        POST_DELAY,
        POST_READY,
        POST_RSTPOLL
    } post_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PTR,
        S_CMD,
        S_COL,
        S_ROW_LO,
        S_ROW_MID,
        S_ROW_HI,
        S_DELAY,
        S_RST_STAT,
        S_WSTART,
        S_WAIT,
        S_DONE
    } state_t;

    // Opcodes whose column is never scaled for a wide bus
    function automatic logic narrow_only(input logic [7:0] op);
        return (op == OP_READID) || (op == OP_GETFEAT) || (op == OP_SETFEAT);
    endfunction

endpackage

// File: rtl/nand_sp_decode.sv
module nand_sp_decode
    import nand_sp_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int PAGE_SIZE = 512
) (
    input  logic [7:0]       opcode,
    input  logic             col_valid,
    input  logic [COL_W-1:0] col,
    input  logic             page_valid,
    input  logic             bus16,
    input  logic             busy_pin,
    output logic             need_ptr,
    output logic [7:0]       ptr_op,
    output logic [7:0]       col_byte,
    output post_t            post
);
    localparam logic [COL_W-1:0] PS   = COL_W'(PAGE_SIZE);
    localparam logic [COL_W-1:0] HALF = COL_W'(PAGE_SIZE / 2);

    logic [COL_W-1:0] rebased;
    logic [COL_W-1:0] scaled;
    logic             unused_hi;

    // Region pointer selection and column rebasing for program setup
    always_comb begin
        need_ptr = (opcode == OP_SEQIN);
        ptr_op   = OP_READ0;
        rebased  = col;
        if (need_ptr && col_valid) begin
            if (col >= PS) begin
                ptr_op  = OP_READOOB;
                rebased = col - PS;
            end else if (col >= HALF) begin
                ptr_op  = OP_READ1;
                rebased = col - HALF;
            end
        end
    end

    always_comb begin
        scaled = rebased;
        if (bus16 && !narrow_only(opcode))
            scaled = rebased >> 1;
    end

    assign col_byte  = scaled[7:0];
    assign unused_hi = ^scaled[COL_W-1:8];

    // Ending class for the request
    always_comb begin
        unique case (opcode)
            OP_PAGEPROG, OP_ERASE1, OP_ERASE2, OP_SEQIN,
            OP_STATUS, OP_READID, OP_SETFEAT:
                post = POST_NONE;
            OP_RESET:
                post = busy_pin ? POST_READY : POST_RSTPOLL;
            OP_READ0:
                if (!col_valid && !page_valid)
                    post = POST_NONE;
                else
                    post = busy_pin ? POST_READY : POST_DELAY;
            default:
                post = busy_pin ? POST_READY : POST_DELAY;
        endcase
    end

endmodule

// File: rtl/nand_sp_delay.sv
module nand_sp_delay #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic             run;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= load_val;
        end else if (run) begin
            if (cnt == '0)
                run <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && (cnt == '0);

    // R8: a new delay is only started when the counter is free
    a_r8_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !run);

    // R8: a running delay counts down by one per clock
    a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0 && !load) |=> (run && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nand_sp_seq.sv
module nand_sp_seq
    import nand_sp_pkg::*;
#(
    parameter int COL_W          = 10,
    parameter int PAGE_W         = 24,
    parameter int PAGE_SIZE      = 512,
    parameter int CHIP_DELAY_CYC = 20,
    parameter int TWB_CYC        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_opcode,
    input  logic              req_col_valid,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_page_valid,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              cfg_bus16,
    input  logic              cfg_row3,
    input  logic              cfg_busy_pin,
    output logic              cyc_valid,
    output logic              cyc_is_addr,
    output logic [7:0]        cyc_byte,
    output logic              wait_start,
    output logic              wait_poll,
    input  logic              wait_done,
    output logic              op_done
);
    localparam int DLY_MAX = (CHIP_DELAY_CYC > TWB_CYC) ? CHIP_DELAY_CYC : TWB_CYC;
    localparam int CNT_W   = $clog2(DLY_MAX + 1);
    localparam logic [CNT_W-1:0] CHIP_LOAD = CNT_W'(CHIP_DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] TWB_LOAD  = CNT_W'(TWB_CYC - 1);

    state_t state, nxt;

    logic              dec_need_ptr;
    logic [7:0]        dec_ptr_op;
    logic [7:0]        dec_col_byte;
    post_t             dec_post;

    logic [7:0]        op_q;
    logic [7:0]        ptr_q;
    logic [7:0]        col_q;
    logic              colv_q;
    logic              pagev_q;
    logic [PAGE_W-1:0] page_q;
    logic              row3_q;
    post_t             post_q;

    logic              dly_load;
    logic [CNT_W-1:0]  dly_val;
    logic              dly_expire;
    state_t            after_addr;

    nand_sp_decode #(
        .COL_W     (COL_W),
        .PAGE_SIZE (PAGE_SIZE)
    ) u_decode (
        .opcode     (req_opcode),
        .col_valid  (req_col_valid),
        .col        (req_col),
        .page_valid (req_page_valid),
        .bus16      (cfg_bus16),
        .busy_pin   (cfg_busy_pin),
        .need_ptr   (dec_need_ptr),
        .ptr_op     (dec_ptr_op),
        .col_byte   (dec_col_byte),
        .post       (dec_post)
    );

    nand_sp_delay #(
        .CNT_W (CNT_W)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .expire   (dly_expire)
    );

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= '0;
            ptr_q   <= '0;
            col_q   <= '0;
            colv_q  <= 1'b0;
            pagev_q <= 1'b0;
            page_q  <= '0;
            row3_q  <= 1'b0;
            post_q  <= POST_NONE;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                op_q    <= req_opcode;
                ptr_q   <= dec_ptr_op;
                col_q   <= dec_col_byte;
                colv_q  <= req_col_valid;
                pagev_q <= req_page_valid;
                page_q  <= req_page;
                row3_q  <= cfg_row3;
                post_q  <= dec_post;
            end
        end
    end

    always_comb begin
        after_addr = (post_q == POST_NONE) ? S_DONE : S_DELAY;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (req_valid) nxt = dec_need_ptr ? S_PTR : S_CMD;
            S_PTR:      nxt = S_CMD;
            S_CMD:      nxt = colv_q ? S_COL : (pagev_q ? S_ROW_LO : after_addr);
            S_COL:      nxt = pagev_q ? S_ROW_LO : after_addr;
            S_ROW_LO:   nxt = S_ROW_MID;
            S_ROW_MID:  nxt = row3_q ? S_ROW_HI : after_addr;
            S_ROW_HI:   nxt = after_addr;
            S_DELAY:
                if (dly_expire) begin
                    if (post_q == POST_DELAY)
                        nxt = S_DONE;
                    else if (post_q == POST_READY)
                        nxt = S_WSTART;
                    else
                        nxt = S_RST_STAT;
                end
            S_RST_STAT: nxt = S_WSTART;
            S_WSTART:   nxt = S_WAIT;
            S_WAIT:     if (wait_done) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    assign dly_load = (nxt == S_DELAY) && (state != S_DELAY);
    assign dly_val  = (post_q == POST_READY) ? TWB_LOAD : CHIP_LOAD;

    // Output logic
    always_comb begin
        req_ready   = 1'b0;
        cyc_valid   = 1'b0;
        cyc_is_addr = 1'b0;
        cyc_byte    = 8'h00;
        wait_start  = 1'b0;
        wait_poll   = 1'b0;
        op_done     = 1'b0;
        unique case (state)
            S_IDLE:     req_ready = 1'b1;
            S_PTR:      begin cyc_valid = 1'b1; cyc_byte = ptr_q; end
            S_CMD:      begin cyc_valid = 1'b1; cyc_byte = op_q; end
            S_COL:      begin cyc_valid = 1'b1; cyc_is_addr = 1'b1; cyc_byte = col_q; end
            S_ROW_LO:   begin cyc_valid = 1'b1; cyc_is_addr = 1'b1; cyc_byte = page_q[7:0]; end
            S_ROW_MID:  begin cyc_valid = 1'b1; cyc_is_addr = 1'b1; cyc_byte = page_q[15:8]; end
            S_ROW_HI:   begin cyc_valid = 1'b1; cyc_is_addr = 1'b1; cyc_byte = page_q[23:16]; end
            S_RST_STAT: begin cyc_valid = 1'b1; cyc_byte = OP_STATUS; end
            S_WSTART:   begin wait_start = 1'b1; wait_poll = (post_q == POST_RSTPOLL); end
            S_DONE:     op_done = 1'b1;
            default:    ;
        endcase
    end

    // R1: taking a request closes the handshake on the next clock
    a_r1_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1: completion reopens the handshake
    a_r1_done_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> req_ready);

    // R2: a program-setup command is always preceded by a command cycle
    a_r2_ptr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_is_addr && cyc_byte == OP_SEQIN) |->
            $past(cyc_valid && !cyc_is_addr));

    // R5: the low page byte is always followed by another address cycle
    a_r5_row_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ROW_LO) |=> (cyc_valid && cyc_is_addr));

    // R9: the wait engine start is a single-clock pulse
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wait_start |=> !wait_start);

    // R6: no latch cycle and completion pulse coincide
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!cyc_valid && !wait_start));

endmodule

// File: tb/tb_nand_sp_seq.sv
`timescale 1ns/1ps
module tb_nand_sp_seq;

    localparam int DLY = 20;
    localparam int TWB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic        req_col_valid = 1'b0;
    logic [9:0]  req_col = '0;
    logic        req_page_valid = 1'b0;
    logic [23:0] req_page = '0;
    logic        cfg_bus16 = 1'b0;
    logic        cfg_row3 = 1'b0;
    logic        cfg_busy_pin = 1'b0;
    logic        cyc_valid, cyc_is_addr;
    logic [7:0]  cyc_byte;
    logic        wait_start, wait_poll;
    logic        wait_done = 1'b0;
    logic        op_done;

    int checks = 0;
    int failures = 0;

    int exp_len, exp_ws, exp_poll, exp_done;
    int exp_k [8];
    int exp_b [8];
    int cap_len, cap_ws, cap_poll, cap_done;
    int cap_k [8];
    int cap_b [8];
    int ready_bad;

    always #2 clk = ~clk;

    nand_sp_seq #(
        .CHIP_DELAY_CYC (DLY),
        .TWB_CYC        (TWB)
    ) dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_opcode,
        .req_col_valid, .req_col, .req_page_valid, .req_page,
        .cfg_bus16, .cfg_row3, .cfg_busy_pin,
        .cyc_valid, .cyc_is_addr, .cyc_byte,
        .wait_start, .wait_poll, .wait_done, .op_done
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic exp_clear();
        exp_len = 0; exp_ws = -1; exp_poll = 0; exp_done = 0;
    endtask

    task automatic exp_add(input int k, input int b);
        exp_k[exp_len] = k; exp_b[exp_len] = b; exp_len++;
    endtask

    task automatic run_req(input logic [7:0] op, input bit cv, input int col,
                           input bit pv, input int page, input bit b16,
                           input bit r3, input bit busy);
        int n;
        int wd_at;
        bit fin;
        @(negedge clk);
        req_opcode = op; req_col_valid = cv; req_col = 10'(col);
        req_page_valid = pv; req_page = 24'(page);
        cfg_bus16 = b16; cfg_row3 = r3; cfg_busy_pin = busy;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; fin = 0; wd_at = -1;
        cap_len = 0; cap_ws = -1; cap_poll = 0; cap_done = -1; ready_bad = 0;
        while (!fin && n < 400) begin
            if (cyc_valid && cap_len < 8) begin
                cap_k[cap_len] = int'(cyc_is_addr);
                cap_b[cap_len] = int'(cyc_byte);
                cap_len++;
            end
            if (wait_start) begin
                cap_ws = n; cap_poll = int'(wait_poll); wd_at = n + 3;
            end
            if (n == wd_at) wait_done = 1'b1;
            if (op_done) begin
                cap_done = n; fin = 1; wait_done = 1'b0;
            end else if (req_ready) begin
                ready_bad = 1;
            end
            if (!fin) begin
                @(negedge clk);
                n++;
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(cap_len == exp_len, tag, "latch cycle count", cap_len, exp_len);
        for (int i = 0; i < exp_len && i < cap_len; i++) begin
            chk(cap_k[i] == exp_k[i], tag, $sformatf("cycle %0d addr flag", i), cap_k[i], exp_k[i]);
            chk(cap_b[i] == exp_b[i], tag, $sformatf("cycle %0d byte", i), cap_b[i], exp_b[i]);
        end
        chk(cap_ws == exp_ws, tag, "wait_start clock", cap_ws, exp_ws);
        if (exp_ws >= 0)
            chk(cap_poll == exp_poll, tag, "wait_poll", cap_poll, exp_poll);
        chk(cap_done == exp_done, tag, "op_done clock", cap_done, exp_done);
        chk(ready_bad == 0, "R1", "req_ready low while busy", ready_bad, 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after op_done", int'(req_ready), 1);
    endtask

    task automatic t_reset_state();
        chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
        chk(cyc_valid == 1'b0, "R1", "reset cyc_valid", int'(cyc_valid), 0);
        chk(wait_start == 1'b0 && op_done == 1'b0, "R1", "reset wait_start/op_done",
            int'({wait_start, op_done}), 0);
    endtask

    task automatic t_prog_first_half();   // R2 R3 R5 R6
        exp_clear();
        exp_add(0, 8'h00); exp_add(0, 8'h80); exp_add(1, 8'h0A);
        exp_add(1, 8'h34); exp_add(1, 8'h12);
        exp_done = 5;
        run_req(8'h80, 1, 10, 1, 24'h001234, 0, 0, 0);
        compare("R2");
    endtask

    task automatic t_prog_second_half();  // R2
        exp_clear();
        exp_add(0, 8'h01); exp_add(0, 8'h80); exp_add(1, 8'h2C);
        exp_add(1, 8'h07); exp_add(1, 8'h00);
        exp_done = 5;
        run_req(8'h80, 1, 300, 1, 24'h000007, 0, 0, 1);
        compare("R2");
    endtask

    task automatic t_prog_spare_row3();   // R2 R5
        exp_clear();
        exp_add(0, 8'h50); exp_add(0, 8'h80); exp_add(1, 8'h03);
        exp_add(1, 8'hDE); exp_add(1, 8'hBC); exp_add(1, 8'h0A);
        exp_done = 6;
        run_req(8'h80, 1, 515, 1, 24'h0ABCDE, 0, 1, 0);
        compare("R5");
    endtask

    task automatic t_prog_wide_bus();     // R4
        exp_clear();
        exp_add(0, 8'h01); exp_add(0, 8'h80); exp_add(1, 8'h16);
        exp_done = 3;
        run_req(8'h80, 1, 300, 0, 0, 1, 0, 0);
        compare("R4");
    endtask

    task automatic t_prog_no_column();    // R2
        exp_clear();
        exp_add(0, 8'h00); exp_add(0, 8'h80); exp_add(1, 8'h01); exp_add(1, 8'h02);
        exp_done = 4;
        run_req(8'h80, 0, 0, 1, 24'h000201, 0, 0, 0);
        compare("R2");
    endtask

    task automatic t_readid_wide();       // R4 R6
        exp_clear();
        exp_add(0, 8'h90); exp_add(1, 8'h20);
        exp_done = 2;
        run_req(8'h90, 1, 8'h20, 0, 0, 1, 0, 1);
        compare("R4");
    endtask

    task automatic t_read_delay();        // R8 R4
        exp_clear();
        exp_add(0, 8'h00); exp_add(1, 8'h20); exp_add(1, 8'h55); exp_add(1, 8'h00);
        exp_done = 4 + DLY;
        run_req(8'h00, 1, 8'h40, 1, 24'h000055, 1, 0, 0);
        compare("R8");
    endtask

    task automatic t_read_exit();         // R7
        exp_clear();
        exp_add(0, 8'h00);
        exp_done = 1;
        run_req(8'h00, 0, 0, 0, 0, 0, 0, 1);
        compare("R7");
    endtask

    task automatic t_read_busy();         // R9
        exp_clear();
        exp_add(0, 8'h00); exp_add(1, 8'h00); exp_add(1, 8'h01); exp_add(1, 8'h00);
        exp_ws = 4 + TWB; exp_poll = 0; exp_done = 4 + TWB + 4;
        run_req(8'h00, 1, 0, 1, 24'h000001, 0, 0, 1);
        compare("R9");
    endtask

    task automatic t_reset_poll();        // R10
        exp_clear();
        exp_add(0, 8'hFF); exp_add(0, 8'h70);
        exp_ws = DLY + 2; exp_poll = 1; exp_done = DLY + 6;
        run_req(8'hFF, 0, 0, 0, 0, 0, 0, 0);
        compare("R10");
    endtask

    task automatic t_reset_busy();        // R9
        exp_clear();
        exp_add(0, 8'hFF);
        exp_ws = 1 + TWB; exp_poll = 0; exp_done = 1 + TWB + 4;
        run_req(8'hFF, 0, 0, 0, 0, 0, 0, 1);
        compare("R9");
    endtask

    task automatic t_erase_no_wait();     // R6 R5
        exp_clear();
        exp_add(0, 8'h60); exp_add(1, 8'h56); exp_add(1, 8'h34); exp_add(1, 8'h00);
        exp_done = 4;
        run_req(8'h60, 0, 0, 1, 24'h003456, 0, 1, 1);
        compare("R6");
    endtask

    task automatic t_read1_delay();       // R8 R3
        exp_clear();
        exp_add(0, 8'h01); exp_add(1, 8'h05);
        exp_done = 2 + DLY;
        run_req(8'h01, 1, 5, 0, 0, 0, 0, 0);
        compare("R3");
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_prog_first_half();
        t_prog_second_half();
        t_prog_spare_row3();
        t_prog_wide_bus();
        t_prog_no_column();
        t_readid_wide();
        t_read_delay();
        t_read_exit();
        t_read_busy();
        t_reset_poll();
        t_reset_busy();
        t_erase_no_wait();
        t_read1_delay();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule